// File: doc/BRIEF.md
# Search Triplet Sequencer

This block carries out a single branch decision of the serial-bus device identity search. After a start request it asks an external bit-slot engine for two read slots. The first returns the identity bit that the devices on the bus hold at the current position. The second returns the complement of that bit. From the pair it picks the branch to follow and sends that branch back as a write slot, so that devices on the other branch drop out. The full walk over the identity, discrepancy bookkeeping and the check code are handled elsewhere.

A caller supplies a preferred branch with the start request. The block uses that branch only when the bus reports a conflict, meaning both read bits are 0. When only one read bit is 1, the bus has already decided the branch. When both read bits are 1, no device answered. In that case the block sends no write slot and reports an error pattern so that the caller can restart the search.

The slot engine interface is a level request held until a one-cycle acknowledge. The write value travels with the request; a read slot is a slot that drives 1 and samples the bus. The result comes back as a 3-bit status together with a one-cycle done strobe.

Top module: `search_triplet`

## Requirements
- R1: After reset the block is idle: slot_req_o, busy_o and done_o are 0 and status_o is 3'b000.
- R2: A start request issues exactly two read slots in order, the identity bit first and the complement second; both are requested with slot_wbit_o = 1.
- R3: The status layout is fixed: bit 0 is the identity bit read, bit 1 is the complement bit read, bit 2 is the branch taken.
- R4: If both read bits are 1, the status is 3'b011, no third slot is requested, and done_o follows the acknowledge of the second read.
- R5: If both read bits are 0, the preferred branch is written; the status is 3'b100 for a preferred 1 and 3'b000 for a preferred 0.
- R6: If exactly one read bit is 1, the branch is forced to the identity bit; the status is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R7: When the pair is not 11, a third slot follows the two reads, with slot_wbit_o equal to the branch taken.
- R8: done_o is high for exactly one cycle, in the cycle after the last slot acknowledge. status_o stays unchanged until the next done.
- R9: The preferred branch is sampled with the accepted start. A start or a preferred-branch change while busy_o is 1 is ignored.
- R10: slot_req_o stays high with a stable slot_wbit_o until slot_ack_i, and slot_ack_i is ignored while no slot is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one triplet (taken only when idle) |
| pref_dir_i | input | 1 | Preferred branch used on a conflict |
| slot_req_o | output | 1 | Slot request to the bit-slot engine |
| slot_wbit_o | output | 1 | Value to drive in the requested slot (1 for read slots) |
| slot_ack_i | input | 1 | One-cycle slot completion from the engine |
| slot_rbit_i | input | 1 | Sampled bus level, valid with slot_ack_i |
| busy_o | output | 1 | Triplet in progress |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 3 | {branch, complement bit, identity bit} |

## Verification
The hardest case to reach is a second start request, with a different preferred branch, that arrives while a conflict triplet is still waiting on its slot engine. The bench reaches it with a slot responder that holds back each acknowledge for a chosen number of cycles. It pulses start with the inverted preference between the two reads. It then checks that only three slots occur and that the original preference is written. Responses with zero latency, where each acknowledge comes the cycle the request is seen, cover the back-to-back slot path.

// File: rtl/triplet_pkg.sv
// Shared definitions for the search triplet sequencer.
// Assumes: status bit order is fixed and decoded by the search walker.
package triplet_pkg;
    localparam int STAT_W   = 3;
    localparam int STAT_ID  = 0;
    localparam int STAT_CMP = 1;
    localparam int STAT_DIR = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR_DIR = 2'd3
    } trip_state_t;
endpackage

// File: rtl/triplet_decide.sv
// Branch decision for one triplet: maps identity/complement bits and the
// preferred branch to abort flag, branch taken and packed status.
// Assumes: inputs are stable when the result is used (pure combinational).
module triplet_decide
    import triplet_pkg::*;
(
    input  logic              id_bit_i,
    input  logic              cmp_bit_i,
    input  logic              pref_i,
    output logic              abort_o,
    output logic              dir_o,
    output logic [STAT_W-1:0] stat_o
);
    // Choose branch: conflict uses preference, single one follows identity bit.
    always_comb begin
        abort_o = id_bit_i & cmp_bit_i;
        if (!id_bit_i && !cmp_bit_i) dir_o = pref_i;
        else if (abort_o)            dir_o = 1'b0;
        else                         dir_o = id_bit_i;
        stat_o           = '0;
        stat_o[STAT_ID]  = id_bit_i;
        stat_o[STAT_CMP] = cmp_bit_i;
        stat_o[STAT_DIR] = dir_o;
    end
endmodule

// File: rtl/triplet_seq.sv
// Slot sequencer: requests read, read, then (unless aborted) a write slot,
// and signals completion with the packed status.
// Assumes: the slot engine acknowledges each request with a one-cycle pulse.
module triplet_seq
    import triplet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pref_i,
    input  logic              slot_ack_i,
    input  logic              slot_rbit_i,
    input  logic              dec_abort_i,
    input  logic              dec_dir_i,
    input  logic [STAT_W-1:0] dec_stat_i,
    output logic              id_q_o,
    output logic              pref_q_o,
    output logic              slot_req_o,
    output logic              slot_wbit_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic [STAT_W-1:0] fin_stat_o
);
    trip_state_t       state;
    logic              id_q, pref_q, dir_q;
    logic [STAT_W-1:0] stat_q;

    // State walk and capture of read bits, preference and decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            id_q   <= 1'b0;
            pref_q <= 1'b0;
            dir_q  <= 1'b0;
            stat_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    pref_q <= pref_i;
                    state  <= ST_RD_ID;
                end
                ST_RD_ID: if (slot_ack_i) begin
                    id_q  <= slot_rbit_i;
                    state <= ST_RD_CMP;
                end
                ST_RD_CMP: if (slot_ack_i) begin
                    stat_q <= dec_stat_i;
                    dir_q  <= dec_dir_i;
                    state  <= dec_abort_i ? ST_IDLE : ST_WR_DIR;
                end
                ST_WR_DIR: if (slot_ack_i) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Slot command and completion outputs.
    always_comb begin
        slot_req_o  = (state != ST_IDLE);
        busy_o      = (state != ST_IDLE);
        slot_wbit_o = (state == ST_WR_DIR) ? dir_q : 1'b1;
        fin_o       = slot_ack_i && ((state == ST_WR_DIR) ||
                                     ((state == ST_RD_CMP) && dec_abort_i));
        fin_stat_o  = (state == ST_WR_DIR) ? stat_q : dec_stat_i;
        id_q_o      = id_q;
        pref_q_o    = pref_q;
    end

    // R10: a pending request holds with stable value until acknowledged.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_ack_i) |=> (slot_req_o && $stable(slot_wbit_o)));

    // R9: a triplet only begins from an accepted start request.
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R2: the slot after a completed first read is again a read slot.
    assert_second_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ID && slot_ack_i) |=> (slot_req_o && slot_wbit_o));
endmodule

// File: rtl/triplet_result.sv
// Result register: presents the packed status with a one-cycle done strobe
// and holds it until the next completion.
// Assumes: fin_i is a single-cycle pulse from the sequencer.
module triplet_result
    import triplet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_i,
    input  logic [STAT_W-1:0] fin_stat_i,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    // Register status and strobe on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            status_o <= '0;
        end else begin
            done_o <= fin_i;
            if (fin_i) status_o <= fin_stat_i;
        end
    end

    // R8: done lasts exactly one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: status only moves on a completion.
    assert_status_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(status_o));

    // R4: an error pattern never reports a branch.
    assert_abort_no_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o[STAT_ID] && status_o[STAT_CMP]) |-> !status_o[STAT_DIR]);

    // R6: a single one always reports the identity bit as the branch.
    assert_forced_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (status_o[STAT_ID] != status_o[STAT_CMP])) |->
            (status_o[STAT_DIR] == status_o[STAT_ID]));
endmodule

// File: rtl/search_triplet.sv
// Top of the search triplet sequencer: sequencer, decision and result stages.
// Assumes: one bit-slot engine, one outstanding slot at a time.
module search_triplet
    import triplet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pref_dir_i,
    output logic              slot_req_o,
    output logic              slot_wbit_o,
    input  logic              slot_ack_i,
    input  logic              slot_rbit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    logic              id_q, pref_q, dec_abort, dec_dir, fin;
    logic [STAT_W-1:0] dec_stat, fin_stat;

    triplet_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pref_i      (pref_dir_i),
        .slot_ack_i  (slot_ack_i),
        .slot_rbit_i (slot_rbit_i),
        .dec_abort_i (dec_abort),
        .dec_dir_i   (dec_dir),
        .dec_stat_i  (dec_stat),
        .id_q_o      (id_q),
        .pref_q_o    (pref_q),
        .slot_req_o  (slot_req_o),
        .slot_wbit_o (slot_wbit_o),
        .busy_o      (busy_o),
        .fin_o       (fin),
        .fin_stat_o  (fin_stat)
    );

    triplet_decide u_dec (
        .id_bit_i  (id_q),
        .cmp_bit_i (slot_rbit_i),
        .pref_i    (pref_q),
        .abort_o   (dec_abort),
        .dir_o     (dec_dir),
        .stat_o    (dec_stat)
    );

    triplet_result u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_i      (fin),
        .fin_stat_i (fin_stat),
        .done_o     (done_o),
        .status_o   (status_o)
    );
endmodule

// File: tb/tb_search_triplet.sv
`timescale 1ns/1ps
module tb_search_triplet;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       slot_ack_i = 1'b0;
    logic       slot_rbit_i = 1'b0;
    logic       slot_req_o, slot_wbit_o, busy_o, done_o;
    logic [2:0] status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 0;

    always #4 clk = ~clk;

    search_triplet dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
        .slot_req_o(slot_req_o), .slot_wbit_o(slot_wbit_o),
        .slot_ack_i(slot_ack_i), .slot_rbit_i(slot_rbit_i),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    // Runs one triplet with a slot responder of latency lat; glitch pulses
    // start with inverted preference while the block is busy.
    task automatic run_case(input string req, input bit pref, input bit idb,
                            input bit cmpb, input int lat, input bit glitch,
                            input logic [2:0] exp_stat, input int exp_slots);
        int   nslot = 0;
        int   wait_n = 0;
        bit   got_done = 0;
        bit   glitched = 0;
        logic first_w = 1'b0;
        logic [2:0] wb = 3'b000;
        @(negedge clk);
        start_i = 1'b1; pref_dir_i = pref;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
            @(negedge clk);
            if (start_i) begin start_i = 1'b0; pref_dir_i = pref; end
            if (slot_ack_i) begin
                slot_ack_i = 1'b0;
            end else if (slot_req_o) begin
                if (wait_n == 0) first_w = slot_wbit_o;
                if (wait_n >= lat) begin
                    chk(slot_wbit_o == first_w, "R10", "wbit stable", slot_wbit_o, first_w);
                    if (nslot < 3) wb[nslot] = slot_wbit_o;
                    slot_rbit_i = (nslot == 0) ? idb : (nslot == 1) ? cmpb : 1'b1;
                    slot_ack_i = 1'b1;
                    nslot++;
                    wait_n = 0;
                end else begin
                    wait_n++;
                end
                if (glitch && !glitched && nslot == 1) begin
                    glitched = 1; start_i = 1'b1; pref_dir_i = ~pref;
                end
            end
            if (done_o) got_done = 1;
        end
        chk(got_done, req, "done seen", got_done, 1);
        chk(status_o == exp_stat, req, "status (R3 layout)", status_o, exp_stat);
        chk(nslot == exp_slots, req, "slot count", nslot, exp_slots);
        chk(wb[0] == 1'b1 && wb[1] == 1'b1, "R2", "read slots drive 1", wb[1:0], 3);
        if (exp_slots == 3)
            chk(wb[2] == exp_stat[2], "R7", "write slot value", wb[2], exp_stat[2]);
        @(negedge clk);
        slot_ack_i = 1'b0;
        chk(!done_o, "R8", "done width", done_o, 0);
        chk(status_o == exp_stat, "R8", "status held", status_o, exp_stat);
        repeat (3) @(negedge clk);
        chk(!slot_req_o && !busy_o, "R10", "no extra slot", slot_req_o, 0);
        chk(status_o == exp_stat, "R8", "status held idle", status_o, exp_stat);
    endtask

    // Acknowledge pulsed while idle must not start anything (R10).
    task automatic stray_ack();
        @(negedge clk);
        slot_ack_i = 1'b1; slot_rbit_i = 1'b1;
        @(negedge clk);
        slot_ack_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy_o && !slot_req_o && !done_o, "R10", "stray ack ignored", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!slot_req_o && !busy_o && !done_o, "R1", "idle after reset", slot_req_o, 0);
        chk(status_o == 3'b000, "R1", "status after reset", status_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case("R5", 1'b0, 1'b0, 1'b0, 2, 1'b0, 3'b000, 3);
        run_case("R5", 1'b1, 1'b0, 1'b0, 1, 1'b0, 3'b100, 3);
        run_case("R6", 1'b0, 1'b1, 1'b0, 3, 1'b0, 3'b101, 3);
        run_case("R6", 1'b1, 1'b0, 1'b1, 0, 1'b0, 3'b010, 3);
        run_case("R4", 1'b1, 1'b1, 1'b1, 2, 1'b0, 3'b011, 2);
        run_case("R4", 1'b0, 1'b1, 1'b1, 0, 1'b0, 3'b011, 2);
        run_case("R9", 1'b1, 1'b0, 1'b0, 4, 1'b1, 3'b100, 3);
        run_case("R9", 1'b0, 1'b0, 1'b0, 4, 1'b1, 3'b000, 3);
        stray_ack();
        run_case("R5", 1'b1, 1'b0, 1'b0, 0, 1'b0, 3'b100, 3);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule